// File: doc/BRIEF.md
# UTOPIA Level 2 Transmit Master

This block drives the transmit half of a multi-PHY UTOPIA level 2 link from the ATM-layer side. An internal cell source offers one cell at a time. It raises `src_valid` and presents the first beat together with the target PHY address. The block learns which PHYs have room for a cell by placing their addresses on the shared 5-bit address bus and reading the cell-available lines one clock later. It then selects the target PHY and streams the cell onto the data bus with start-of-cell, enable and odd parity.

The data bus runs as 8 bits or 16 bits. The mode is taken from `wide_mode` when a cell starts. A cell is 53 byte beats in 8-bit mode and 27 word beats in 16-bit mode. In 16-bit mode the source supplies each word with its earlier byte on bits 15:8. The block fills the low byte of word 2 (the word that carries the header check byte) with the pad value. Within a cell, a source beat accepted on one edge appears on the bus after that edge. When the source pauses, the bus holds and enable drops.

Top module: `utx_master`

## Requirements
- R1: While reset is held, `tx_en`, `tx_soc` and `src_ready` are 0 and `tx_addr` is the null address 5'h1F.
- R2: Outside a cell the block polls, one address per clock, the PHYs in 0..NUM_PHY-1 whose room is not yet recorded, in ascending ring order. When every PHY has recorded room it drives 5'h1F.
- R3: Cell-available for a polled address is read one clock after that address is presented, from line (address mod CLAV_LINES). The other lines are ignored.
- R4: No cell starts to a PHY whose last sampled cell-available was 0. `src_ready` stays 0 and `tx_en` stays 0 while the block waits.
- R5: The selected PHY address is driven for at least one clock with `tx_en` low before the first beat, and it holds until the last beat has left the bus.
- R6: `tx_soc` is 1 only together with the first beat of a cell.
- R7: When the source has no beat in the middle of a cell, `tx_en` is 0, `tx_data` holds, and the next beat carries no `tx_soc`.
- R8: In 8-bit mode a cell is exactly 53 beats, the byte is on `tx_data[7:0]` and `tx_data[15:8]` is 8'h00.
- R9: In 16-bit mode a cell is exactly 27 beats, the source word passes unchanged, except that the low byte of beat 2 (counting from 0) is replaced by PAD_BYTE (default 8'h00).
- R10: `tx_par` makes the count of ones over `tx_par` and the active data bits (8 or 16) odd.
- R11: A change of `wide_mode` during a cell does not change that cell's width or length.
- R12: After a cell to a PHY, that PHY must be polled again and report room before a further cell to it starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 selects the 16-bit bus, 0 the 8-bit bus; taken at cell start |
| src_valid | input | 1 | Source offers a beat |
| src_ready | output | 1 | Block takes the offered beat at the next edge |
| src_data | input | 16 | Source beat; low byte only in 8-bit mode |
| src_phy | input | 5 | Target PHY of the offered cell |
| tx_data | output | 16 | Data bus to the PHYs, bit 15 most significant |
| tx_soc | output | 1 | Start of cell |
| tx_en | output | 1 | Valid data on the bus |
| tx_par | output | 1 | Odd parity over the active data bits |
| tx_addr | output | 5 | PHY address bus, bit 4 most significant |
| tx_clav | input | 4 | Cell-available lines from the PHYs |

## Verification
If the room table is wrong, a cell either leaves for a PHY that reported no room, within about NUM_PHY clocks of the source offering it, or the cell stalls with `src_ready` low. A beat counter that is off shows on the bus as a cell that is one beat short or long. It also shows as the pad landing in a word other than word 2. Both become visible at the end of that cell. A framer that loses its state during a pause shows a second start-of-cell, or a moved data bus, in the stalled cycle itself.

// File: rtl/utx_pkg.sv
package utx_pkg;

  localparam logic [4:0] ADDR_NULL = 5'h1F;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_SEND,
    FR_LAST
  } fr_state_e;

  // Beats in one cell for the chosen bus width.
  function automatic logic [5:0] beats_per_cell(input logic wide);
    return wide ? 6'd27 : 6'd53;
  endfunction

  // Odd parity bit over the active lanes of the bus.
  function automatic logic odd_parity(input logic [15:0] d, input logic wide);
    logic [15:0] m;
    m = wide ? d : {8'h00, d[7:0]};
    return ~(^m);
  endfunction

  // Bus word for beat idx: narrow lane clears the upper byte,
  // wide lane puts the pad under the header check byte.
  function automatic logic [15:0] shape_beat(input logic wide, input logic [5:0] idx,
                                              input logic [15:0] src, input logic [7:0] pad);
    if (!wide) return {8'h00, src[7:0]};
    if (idx == 6'd2) return {src[15:8], pad};
    return src;
  endfunction

  // Cell-available line that carries a given address.
  function automatic logic [1:0] clav_lane(input logic [4:0] addr, input int lanes);
    int r;
    r = int'(addr) % lanes;
    return r[1:0];
  endfunction

  // Next index on a ring of n PHYs.
  function automatic logic [4:0] ring_next(input logic [4:0] idx, input int n);
    return (int'(idx) + 1 >= n) ? 5'd0 : idx + 5'd1;
  endfunction

endpackage

// File: rtl/utx_poller.sv
module utx_poller
  import utx_pkg::*;
#(
  parameter int NUM_PHY    = 4,
  parameter int CLAV_LINES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         tx_clav,
  input  logic [4:0]         cur_addr,
  input  logic               sample,
  input  logic               advance,
  input  logic               claim,
  input  logic [4:0]         claim_phy,
  output logic [NUM_PHY-1:0] room,
  output logic [4:0]         pick_addr
);

  logic [4:0]  ptr;
  logic [1:0]  lane;
  logic        clav_seen;
  logic [31:0] room_ext;

  assign lane      = clav_lane(cur_addr, CLAV_LINES);
  assign clav_seen = tx_clav[lane];
  assign room_ext  = 32'(room);

  // First PHY without recorded room, searching from ptr around the ring.
  always_comb begin
    int s;
    pick_addr = ADDR_NULL;
    for (int j = NUM_PHY - 1; j >= 0; j--) begin
      s = int'(ptr) + j;
      if (s >= NUM_PHY) s = s - NUM_PHY;
      if (!room[s]) pick_addr = 5'(s);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= 5'd0;
    else if (advance) ptr <= ring_next(pick_addr, NUM_PHY);
  end

  for (genvar g = 0; g < NUM_PHY; g++) begin : g_room
    always_ff @(posedge clk) begin
      if (!rst_n) room[g] <= 1'b0;
      else if (claim && claim_phy == 5'(g)) room[g] <= 1'b0;
      else if (sample && cur_addr == 5'(g)) room[g] <= clav_seen;
    end
  end

  p_sample_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (int'(cur_addr) < NUM_PHY));

  p_claim_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> !room_ext[$past(claim_phy)]);

  p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (int'(ptr) < NUM_PHY));

endmodule

// File: rtl/utx_framer.sv
module utx_framer
  import utx_pkg::*;
#(
  parameter logic [7:0] PAD_BYTE = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wide_mode,
  input  logic        src_valid,
  input  logic [15:0] src_data,
  input  logic        go,
  output logic        src_ready,
  output logic        start,
  output logic        busy,
  output logic [15:0] tx_data,
  output logic        tx_soc,
  output logic        tx_en,
  output logic        tx_par
);

  fr_state_e   st;
  logic [5:0]  cnt;
  logic        wide_q;
  logic        take;
  logic        last_take;
  logic [15:0] beat_next;

  assign start     = (st == FR_IDLE) && src_valid && go;
  assign busy      = (st == FR_SEND);
  assign src_ready = busy;
  assign take      = busy && src_valid;
  assign last_take = take && (cnt == beats_per_cell(wide_q) - 6'd1);
  assign beat_next = shape_beat(wide_q, cnt, src_data, PAD_BYTE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= FR_IDLE;
      cnt     <= 6'd0;
      wide_q  <= 1'b0;
      tx_data <= 16'h0000;
      tx_soc  <= 1'b0;
      tx_en   <= 1'b0;
      tx_par  <= 1'b1;
    end else begin
      case (st)
        FR_IDLE: begin
          tx_en  <= 1'b0;
          tx_soc <= 1'b0;
          if (start) begin
            st     <= FR_SEND;
            cnt    <= 6'd0;
            wide_q <= wide_mode;
          end
        end
        FR_SEND: begin
          if (take) begin
            tx_data <= beat_next;
            tx_par  <= odd_parity(beat_next, wide_q);
            tx_en   <= 1'b1;
            tx_soc  <= (cnt == 6'd0);
            cnt     <= cnt + 6'd1;
            if (last_take) st <= FR_LAST;
          end else begin
            tx_en  <= 1'b0;
            tx_soc <= 1'b0;
          end
        end
        default: begin
          tx_en  <= 1'b0;
          tx_soc <= 1'b0;
          st     <= FR_IDLE;
        end
      endcase
    end
  end

  p_gap_before_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !tx_en);

  p_soc_with_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soc |-> tx_en);

  p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !src_valid) |=> (!tx_en && !tx_soc && $stable(tx_data)));

  p_narrow_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !wide_q) |-> (tx_data[15:8] == 8'h00));

  p_beat_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < beats_per_cell(wide_q)));

  p_odd_parity_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> (^{tx_par, tx_data}));

  p_mode_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wide_q));

endmodule

// File: rtl/utx_master.sv
module utx_master
  import utx_pkg::*;
#(
  parameter int         NUM_PHY    = 4,
  parameter int         CLAV_LINES = 4,
  parameter logic [7:0] PAD_BYTE   = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wide_mode,
  input  logic        src_valid,
  output logic        src_ready,
  input  logic [15:0] src_data,
  input  logic [4:0]  src_phy,
  output logic [15:0] tx_data,
  output logic        tx_soc,
  output logic        tx_en,
  output logic        tx_par,
  output logic [4:0]  tx_addr,
  input  logic [3:0]  tx_clav
);

  logic [NUM_PHY-1:0] room;
  logic [31:0]        room_ext;
  logic [4:0]         pick_addr;
  logic               go;
  logic               cell_start;
  logic               busy;
  logic               poll_issue;
  logic               poll_live;

  assign room_ext   = 32'(room);
  assign go         = (int'(src_phy) < NUM_PHY) && room_ext[src_phy];
  assign poll_issue = !cell_start && !busy && (pick_addr != ADDR_NULL);

  utx_poller #(.NUM_PHY(NUM_PHY), .CLAV_LINES(CLAV_LINES)) u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_clav   (tx_clav),
    .cur_addr  (tx_addr),
    .sample    (poll_live),
    .advance   (poll_issue),
    .claim     (cell_start),
    .claim_phy (src_phy),
    .room      (room),
    .pick_addr (pick_addr)
  );

  utx_framer #(.PAD_BYTE(PAD_BYTE)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide_mode (wide_mode),
    .src_valid (src_valid),
    .src_data  (src_data),
    .go        (go),
    .src_ready (src_ready),
    .start     (cell_start),
    .busy      (busy),
    .tx_data   (tx_data),
    .tx_soc    (tx_soc),
    .tx_en     (tx_en),
    .tx_par    (tx_par)
  );

  // Address bus: selected PHY for a cell, otherwise the poll choice.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_addr   <= ADDR_NULL;
      poll_live <= 1'b0;
    end else if (cell_start) begin
      tx_addr   <= src_phy;
      poll_live <= 1'b0;
    end else if (busy) begin
      poll_live <= 1'b0;
    end else begin
      tx_addr   <= pick_addr;
      poll_live <= poll_issue;
    end
  end

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tx_addr));

  p_null_not_sampled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_addr == ADDR_NULL) |-> !poll_live);

  p_start_with_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (tx_addr == $past(src_phy)));

endmodule

// File: tb/tb_utx_master.sv
module tb_utx_master;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wide_mode;
  logic        src_valid;
  logic        src_ready;
  logic [15:0] src_data;
  logic [4:0]  src_phy;
  logic [15:0] tx_data;
  logic        tx_soc;
  logic        tx_en;
  logic        tx_par;
  logic [4:0]  tx_addr;
  logic [3:0]  tx_clav;

  always #10 clk = ~clk;

  utx_master dut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data), .src_phy(src_phy),
    .tx_data(tx_data), .tx_soc(tx_soc), .tx_en(tx_en), .tx_par(tx_par),
    .tx_addr(tx_addr), .tx_clav(tx_clav)
  );

  // PHY responder: PHY i answers on line i; noise raises every other line.
  logic [3:0] phy_room;
  logic       noise_on;
  always_comb begin
    for (int i = 0; i < 4; i++)
      tx_clav[i] = ((tx_addr == 5'(i)) && phy_room[i]) || (noise_on && tx_addr != 5'(i));
  end

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [15:0] src_word(input logic [7:0] s, input int k);
    logic [7:0] hi, lo;
    hi = s + 8'(2 * k);
    lo = (s + 8'(2 * k + 1)) ^ 8'h5A;
    return {hi, lo};
  endfunction

  function automatic logic [15:0] exp_unit(input bit w, input int k, input logic [7:0] s);
    logic [15:0] x;
    x = src_word(s, k);
    if (!w) return {8'h00, x[7:0]};
    if (k == 2) return {x[15:8], 8'h00};
    return x;
  endfunction

  // Monitor state for the cell in flight.
  int         cur_phy;
  bit         cur_wide;
  logic [7:0] cur_seed;
  int         beats;
  bit         in_cell;
  bit soc_bad, data_bad, par_bad, addr_bad, sel_bad, hold_bad;
  int         bad_act, bad_exp;
  logic [15:0] last_data;
  logic       prev_en;
  logic [4:0] prev_addr;

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_en) begin
        if (tx_soc == in_cell) soc_bad = 1;
        if (tx_soc && !in_cell) begin
          in_cell = 1;
          beats = 0;
          if (prev_en || prev_addr != 5'(cur_phy)) sel_bad = 1;
          phy_room[cur_phy] = 1'b0;
        end
        if (tx_data != exp_unit(cur_wide, beats, cur_seed) && !data_bad) begin
          data_bad = 1;
          bad_act = int'(tx_data);
          bad_exp = int'(exp_unit(cur_wide, beats, cur_seed));
        end
        if (!(^{tx_par, tx_data})) par_bad = 1;
        if (tx_addr != 5'(cur_phy)) addr_bad = 1;
        last_data = tx_data;
        beats++;
      end else if (in_cell && beats < (cur_wide ? 27 : 53)) begin
        if (tx_data != last_data || tx_soc) hold_bad = 1;
      end
    end
    prev_en = tx_en;
    prev_addr = tx_addr;
  end

  task automatic send_cell(input int phy, input bit w, input logic [7:0] seed,
                           input int stall_n, input bit flip);
    int k, t, units;
    bit stl;
    cur_phy = phy; cur_wide = w; cur_seed = seed;
    units = w ? 27 : 53;
    k = 0; t = 0;
    wide_mode = w;
    while (k < units) begin
      stl = (stall_n != 0) && (k > 0) && ((t % stall_n) == stall_n - 1);
      t++;
      src_valid = !stl;
      src_data  = src_word(seed, k);
      src_phy   = 5'(phy);
      if (flip && k == 5) wide_mode = !w;
      if (src_valid && src_ready) k++;
      @(negedge clk);
    end
    src_valid = 1'b0;
    wide_mode = w;
  endtask

  task automatic check_cell(input bit flip);
    string rq;
    repeat (3) @(negedge clk);
    rq = flip ? "R11" : (cur_wide ? "R9" : "R8");
    check(beats == (cur_wide ? 27 : 53), rq, "beat count", beats, cur_wide ? 27 : 53);
    check(!data_bad, rq, "beat data", bad_act, bad_exp);
    check(!soc_bad, "R6", "start-of-cell placement", soc_bad, 0);
    check(!par_bad, "R10", "odd parity", par_bad, 0);
    check(!addr_bad && !sel_bad, "R5", "address select/hold", {addr_bad, sel_bad}, 0);
    check(!hold_bad, "R7", "stall hold", hold_bad, 0);
    in_cell = 0; beats = 0;
    soc_bad = 0; data_bad = 0; par_bad = 0; addr_bad = 0; sel_bad = 0; hold_bad = 0;
  endtask

  task automatic wait_blocked(input int n, input string req);
    bit moved;
    moved = 0;
    repeat (n) begin
      @(negedge clk);
      if (tx_en || src_ready) moved = 1;
    end
    check(!moved, req, "cell started without room", moved, 0);
  endtask

  typedef struct packed {
    logic [3:0] phy;
    logic       wide;
    logic [2:0] stall;
    logic       flip;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{4'd0, 1'b0, 3'd0, 1'b0, 8'h10},
    '{4'd3, 1'b1, 3'd0, 1'b0, 8'h21},
    '{4'd2, 1'b0, 3'd3, 1'b0, 8'h32},
    '{4'd1, 1'b1, 3'd2, 1'b0, 8'h43},
    '{4'd0, 1'b1, 3'd0, 1'b1, 8'h54},
    '{4'd3, 1'b0, 3'd4, 1'b1, 8'h65}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    summary();
  end

  initial begin
    bit seq_ok;
    logic [4:0] a_prev;
    rst_n = 1'b0; wide_mode = 1'b0; src_valid = 1'b0; src_data = 16'h0;
    src_phy = 5'd0; phy_room = 4'h0; noise_on = 1'b0;
    in_cell = 0; beats = 0; bad_act = 0; bad_exp = 0;
    soc_bad = 0; data_bad = 0; par_bad = 0; addr_bad = 0; sel_bad = 0; hold_bad = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(tx_en == 1'b0, "R1", "tx_en in reset", tx_en, 0);
    check(tx_soc == 1'b0, "R1", "tx_soc in reset", tx_soc, 0);
    check(src_ready == 1'b0, "R1", "src_ready in reset", src_ready, 0);
    check(tx_addr == 5'h1F, "R1", "tx_addr in reset", tx_addr, 5'h1F);
    rst_n = 1'b1;

    // R2: ring polling while no PHY has room
    @(negedge clk);
    a_prev = tx_addr;
    seq_ok = (a_prev < 5'd4);
    repeat (8) begin
      @(negedge clk);
      if (tx_addr != ((a_prev == 5'd3) ? 5'd0 : a_prev + 5'd1)) seq_ok = 0;
      a_prev = tx_addr;
    end
    check(seq_ok, "R2", "poll ring order", a_prev, 0);

    // R3 and R4: cell to PHY 1 must wait; noise on other lines ignored
    noise_on = 1'b1;
    fork
      send_cell(1, 1'b0, 8'h40, 0, 1'b0);
      begin
        wait_blocked(20, "R3");
        noise_on = 1'b0;
        wait_blocked(20, "R4");
        phy_room[1] = 1'b1;
      end
    join
    check_cell(1'b0);

    // R12: PHY 1 consumed its room; a further cell must wait for a new poll
    fork
      send_cell(1, 1'b1, 8'h77, 0, 1'b0);
      begin
        wait_blocked(20, "R12");
        phy_room[1] = 1'b1;
      end
    join
    check_cell(1'b0);

    // Vector table: widths, stalls, mode flips
    for (int v = 0; v < 6; v++) begin
      phy_room[VEC[v].phy] = 1'b1;
      send_cell(int'(VEC[v].phy), VEC[v].wide, VEC[v].seed, int'(VEC[v].stall), VEC[v].flip);
      check_cell(VEC[v].flip);
    end

    // R2: every PHY reports room, polling goes to the null address
    phy_room = 4'hF;
    repeat (10) @(negedge clk);
    seq_ok = 1;
    repeat (5) begin
      @(negedge clk);
      if (tx_addr != 5'h1F) seq_ok = 0;
    end
    check(seq_ok, "R2", "null address when idle", tx_addr, 5'h1F);

    summary();
  end

endmodule